// File: doc/BRIEF.md
# Interval Event Detector for a Real-Time Clock

This block raises the periodic "interval event" of a real-time clock. It works in one of two modes, chosen by a mode input. In calendar mode it watches the hour, minute and second values that a separate time-keeping core supplies. It produces a pulse when the minute changes, when the hour changes, when the time reaches midnight, or when the time reaches noon. In counter mode it owns a 32-bit up counter that advances on a count enable. It produces a pulse when the counter wraps at an 8, 16, 24 or 32-bit boundary.

A single 2-bit select chooses the condition, and its meaning depends on the mode. An enable gates the pulse. Software can load the counter and read it back through a simple write port and a read-data output. The pulse is registered and lasts one clock cycle per triggering edge, and it goes to the interrupt controller.

Top module: `interval_event_det`

## Requirements
- R1: While `rst_n` is low, at the next clock edge `evt_o` becomes 0 and `cnt_rdata` becomes 0.
- R2: In calendar mode (`cal_mode`=1) with `evt_sel`=2'b00, `evt_o` is 1 for the cycle after each clock edge at which the sampled `min_i` differs from the value sampled at the previous edge. Otherwise `evt_o` is 0.
- R3: In calendar mode with `evt_sel`=2'b01, `evt_o` is 1 for the cycle after each edge at which the sampled `hour_i` differs from its previous sample.
- R4: In calendar mode with `evt_sel`=2'b10, `evt_o` is 1 for the cycle after the edge at which the sampled time first becomes 00:00:00. It does not fire again while the time stays at 00:00:00.
- R5: In calendar mode with `evt_sel`=2'b11, `evt_o` is 1 for the cycle after the edge at which the sampled time first becomes 12:00:00. It fires only once per occurrence.
- R6: In counter mode (`cal_mode`=0), the counter increases by one at each edge where `cnt_en`=1 and `cnt_wr`=0. It holds otherwise, and it never advances in calendar mode. `cnt_rdata` always shows the counter.
- R7: In counter mode, `evt_o` is 1 for the cycle after an increment that clears the low 8 bits (`evt_sel`=2'b00), the low 16 bits (2'b01), the low 24 bits (2'b10) or all 32 bits (2'b11) of the counter.
- R8: When `cnt_wr`=1, the counter takes `cnt_wdata` at the edge. The load takes priority over an increment, and the load never produces an event.
- R9: When `evt_en`=0 at an edge, `evt_o` is 0 in the following cycle, whatever the condition.
- R10: The first edge after reset only records the time inputs. A calendar event cannot fire on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cal_mode | input | 1 | 1 = calendar mode, 0 = counter mode |
| evt_sel | input | 2 | Event condition select |
| evt_en | input | 1 | Event pulse enable |
| sec_i | input | 6 | Seconds from time-keeping core (binary) |
| min_i | input | 6 | Minutes from time-keeping core (binary) |
| hour_i | input | 5 | Hours from time-keeping core (binary, 0-23) |
| cnt_en | input | 1 | Counter advance enable |
| cnt_wr | input | 1 | Counter load strobe |
| cnt_wdata | input | 32 | Counter load value |
| cnt_rdata | output | 32 | Counter readback |
| evt_o | output | 1 | Registered event pulse |

## Verification
A software load and a count step can land on the same edge. The riskiest form is a load issued while the counter sits at all-ones in its selected low bits, so the step would overflow. The bench raises `cnt_wr` and `cnt_en` together at exactly that count, for every select value. It judges the result with its reference model, which expects the loaded value on the readback and no pulse. It also checks that a load of all-ones followed by a plain step still produces the wrap pulse.

// File: rtl/interval_event_det.sv
module interval_event_det #(
  parameter int SEC_W   = 6,
  parameter int MIN_W   = 6,
  parameter int HR_W    = 5,
  parameter int CNT_W   = 32,
  parameter int NOON_HR = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cal_mode,
  input  logic [1:0]       evt_sel,
  input  logic             evt_en,
  input  logic [SEC_W-1:0] sec_i,
  input  logic [MIN_W-1:0] min_i,
  input  logic [HR_W-1:0]  hour_i,
  input  logic             cnt_en,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic [CNT_W-1:0] cnt_rdata,
  output logic             evt_o
);

  localparam int NSEL = 4;
  localparam int SEG  = CNT_W / NSEL;

  logic [CNT_W-1:0] cnt_q;
  logic [SEC_W-1:0] sec_q;
  logic [MIN_W-1:0] min_q;
  logic [HR_W-1:0]  hour_q;
  logic             primed_q;
  logic             evt_q;
  logic [NSEL-1:0]  seg_full;
  logic             cal_hit;

  genvar g;
  generate
    for (g = 0; g < NSEL; g++) begin : g_seg
      assign seg_full[g] = &cnt_q[(g+1)*SEG-1:0];
    end
  endgenerate

  wire step    = !cal_mode && cnt_en && !cnt_wr;
  wire ovf     = step && seg_full[evt_sel];
  wire now_mid = (hour_i == '0) && (min_i == '0) && (sec_i == '0);
  wire was_mid = (hour_q == '0) && (min_q == '0) && (sec_q == '0);
  wire now_non = (hour_i == HR_W'(NOON_HR)) && (min_i == '0) && (sec_i == '0);
  wire was_non = (hour_q == HR_W'(NOON_HR)) && (min_q == '0) && (sec_q == '0);

  always_comb begin
    case (evt_sel)
      2'b00:   cal_hit = (min_i != min_q);
      2'b01:   cal_hit = (hour_i != hour_q);
      2'b10:   cal_hit = now_mid && !was_mid;
      default: cal_hit = now_non && !was_non;
    endcase
  end

  wire hit = cal_mode ? (primed_q && cal_hit) : ovf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      sec_q    <= '0;
      min_q    <= '0;
      hour_q   <= '0;
      primed_q <= 1'b0;
      evt_q    <= 1'b0;
    end else begin
      sec_q    <= sec_i;
      min_q    <= min_i;
      hour_q   <= hour_i;
      primed_q <= 1'b1;
      evt_q    <= evt_en && hit;
      if (cnt_wr)    cnt_q <= cnt_wdata;
      else if (step) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_rdata = cnt_q;
  assign evt_o     = evt_q;

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (evt_o == 1'b0) && (cnt_rdata == '0));

  // R9
  a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_en |=> !evt_o);

  // R8
  a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt_rdata == $past(cnt_wdata)) && !evt_o);

  // R6
  a_r6_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (!cal_mode && cnt_en && !cnt_wr) |=> cnt_rdata == $past(cnt_rdata) + 1'b1);

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && (cal_mode || !cnt_en)) |=> $stable(cnt_rdata));

  // R7
  a_r7_no_early_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!cal_mode && evt_sel == 2'b00 && cnt_rdata[SEG-1:0] != {SEG{1'b1}}) |=> !evt_o);

  // R4
  a_r4_mid_only_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_mode && evt_sel == 2'b10 && (hour_i != '0 || min_i != '0 || sec_i != '0)) |=> !evt_o);

  // R5
  a_r5_noon_only_at_noon: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_mode && evt_sel == 2'b11 && (hour_i != HR_W'(NOON_HR) || min_i != '0 || sec_i != '0))
      |=> !evt_o);

endmodule

// File: tb/interval_event_det_tb.sv
module interval_event_det_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cal_mode = 1'b1;
  logic [1:0]  evt_sel = 2'b00;
  logic        evt_en = 1'b1;
  logic [5:0]  sec_i = '0;
  logic [5:0]  min_i = '0;
  logic [4:0]  hour_i = '0;
  logic        cnt_en = 1'b0;
  logic        cnt_wr = 1'b0;
  logic [31:0] cnt_wdata = '0;
  logic [31:0] cnt_rdata;
  logic        evt_o;

  always #4 clk = ~clk;

  interval_event_det u_dut (
    .clk(clk), .rst_n(rst_n), .cal_mode(cal_mode), .evt_sel(evt_sel),
    .evt_en(evt_en), .sec_i(sec_i), .min_i(min_i), .hour_i(hour_i),
    .cnt_en(cnt_en), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .cnt_rdata(cnt_rdata), .evt_o(evt_o)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  bit    chk_on = 0;
  bit    done = 0;
  string cur_req = "R1";

  // behavioural reference model
  longint m_cnt = 0;
  int     m_prev_t = 0, m_prev_m = 0, m_prev_h = 0;
  bit     m_primed = 0;
  bit     m_evt = 0;

  always @(posedge clk) begin
    int     t_now;
    bit     hit;
    longint nxt;
    t_now = int'(hour_i) * 3600 + int'(min_i) * 60 + int'(sec_i);
    if (!rst_n) begin
      m_cnt = 0; m_primed = 0; m_evt = 0;
    end else begin
      hit = 0;
      if (cal_mode) begin
        case (evt_sel)
          2'b00: hit = int'(min_i) != m_prev_m;
          2'b01: hit = int'(hour_i) != m_prev_h;
          2'b10: hit = (t_now == 0) && (m_prev_t != 0);
          default: hit = (t_now == 43200) && (m_prev_t != 43200);
        endcase
        hit = hit && m_primed;
      end else if (cnt_en && !cnt_wr) begin
        nxt = m_cnt + 1;
        hit = (nxt % (longint'(1) << (8 * (int'(evt_sel) + 1)))) == 0;
      end
      if (cnt_wr) m_cnt = longint'(cnt_wdata);
      else if (!cal_mode && cnt_en) m_cnt = (m_cnt + 1) % (longint'(1) << 32);
      m_evt = evt_en && hit;
      m_primed = 1;
      m_prev_t = t_now; m_prev_m = int'(min_i); m_prev_h = int'(hour_i);
    end
  end

  always @(negedge clk) begin
    if (chk_on && !done) begin
      n_chk++;
      if (evt_o !== m_evt) begin
        n_bad++;
        $display("FAIL %s evt_o actual=%b expected=%b t=%0t", cur_req, evt_o, m_evt, $time);
      end
      n_chk++;
      if (cnt_rdata !== m_cnt[31:0]) begin
        n_bad++;
        $display("FAIL %s cnt_rdata actual=%h expected=%h t=%0t", cur_req, cnt_rdata, m_cnt[31:0], $time);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_t(input int h, input int m, input int s);
    hour_i = 5'(h); min_i = 6'(m); sec_i = 6'(s);
    tick(1);
  endtask

  task automatic load(input logic [31:0] v);
    cnt_wr = 1'b1; cnt_wdata = v;
    tick(1);
    cnt_wr = 1'b0;
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    hour_i = 5; min_i = 30; sec_i = 10;
    @(posedge clk);
    tick(1);
    chk_on = 1;
    tick(2);
    // R10: first sample after reset must not fire
    cur_req = "R10";
    rst_n = 1'b1;
    tick(3);
    // R2: minute change
    cur_req = "R2";
    set_t(5, 30, 11); set_t(5, 31, 0); set_t(5, 31, 1);
    set_t(5, 32, 1); set_t(5, 33, 1); tick(2);
    // R3: hour change
    cur_req = "R3"; evt_sel = 2'b01; tick(1);
    set_t(5, 59, 59); set_t(6, 0, 0); set_t(6, 1, 0); set_t(7, 1, 0); tick(2);
    // R4: midnight once
    cur_req = "R4"; evt_sel = 2'b10; tick(1);
    set_t(23, 59, 59); set_t(0, 0, 0); tick(3); set_t(0, 0, 1); set_t(0, 0, 0); tick(1);
    // R5: noon once
    cur_req = "R5"; evt_sel = 2'b11; tick(1);
    set_t(11, 59, 59); set_t(12, 0, 0); tick(3); set_t(12, 0, 1); set_t(0, 0, 0); tick(1);
    // R9: disabled enable hides changes
    cur_req = "R9"; evt_sel = 2'b00; evt_en = 1'b0;
    set_t(1, 1, 1); set_t(1, 2, 1); set_t(1, 3, 1);
    evt_en = 1'b1; set_t(1, 4, 1); tick(1);
    // R6: counting rules
    cur_req = "R6"; cnt_en = 1'b1; tick(3);
    cal_mode = 1'b0; tick(4);
    cnt_en = 1'b0; tick(2);
    cnt_en = 1'b1; tick(1); cnt_en = 1'b0; tick(1);
    // R7: each boundary
    cur_req = "R7";
    for (int s = 0; s < 4; s++) begin
      evt_sel = 2'(s);
      load(32'hFFFF_FFFD >> (8 * (3 - s)));
      cnt_en = 1'b1; tick(5); cnt_en = 1'b0; tick(1);
    end
    evt_sel = 2'b00; load(32'h0000_01FE); cnt_en = 1'b1; tick(3);
    evt_sel = 2'b01; load(32'h0000_01FE); tick(3); cnt_en = 1'b0;
    evt_en = 1'b0; evt_sel = 2'b00; load(32'h0000_00FE); cnt_en = 1'b1; tick(3);
    evt_en = 1'b1; cnt_en = 1'b0;
    // R8: load against an overflowing step
    cur_req = "R8";
    for (int s = 0; s < 4; s++) begin
      evt_sel = 2'(s);
      load(32'hFFFF_FFFF >> (8 * (3 - s)));
      cnt_en = 1'b1; cnt_wr = 1'b1; cnt_wdata = 32'h0000_1234; tick(1);
      cnt_wr = 1'b0; cnt_en = 1'b0; tick(1);
    end
    evt_sel = 2'b11; load(32'hFFFF_FFFF); load(32'h0); tick(1);
    load(32'hFFFF_FFFF); cnt_en = 1'b1; tick(2); cnt_en = 1'b0;
    cal_mode = 1'b1; load(32'h0000_0042); tick(2);
    // R1: reset again mid-run
    cur_req = "R1"; cal_mode = 1'b0; cnt_en = 1'b1; rst_n = 1'b0; tick(2);
    rst_n = 1'b1; tick(2);
    finish_up();
  end

endmodule